// File: doc/BRIEF.md
# Receive Clock-Compensation Elastic Buffer

This block moves a stream of 9-bit line symbols from a recovered receive clock into the local core clock. Both clocks run at nominally the same rate but are not locked to each other. The writer stores one symbol per enabled write-clock cycle. The reader hands out exactly one symbol per read-clock cycle, with no stall input. Slow drift between the two clocks is absorbed by changing the length of skip runs. A skip run is a group of consecutive skip symbols that the far end sends on a regular basis. The reader removes one skip from a run when the buffer is too full. It sends one skip twice when the buffer is too empty.

The ring has six entries rather than a power of two. This cuts the time a symbol spends in the buffer. The write position crosses to the read clock as a Gray code. The code counts through twelve states, which is two laps of the six-entry ring, so a full ring and an empty ring have different codes. The twelve states are the central twelve codes of a 4-bit reflected Gray sequence, so every increment flips exactly one bit, including the return to zero. The read side decodes the synchronised code back to a count and keeps an occupancy estimate. It steers that estimate toward three entries, which is half full. It also keeps two sticky error flags.

Top module: `rx_elastic_buf`

## Requirements
- R1: While reset is held and directly after it, `rd_sym` is the idle symbol 9'h17C, and `ovf_flag` and `unf_flag` are 0.
- R2: After reset, `rd_sym` carries only the idle symbol until the read-side occupancy estimate first reaches 3. No underflow is flagged during this wait.
- R3: Every symbol other than the skip symbol 9'h11C leaves in write order. None is lost, repeated or altered. Data symbols have bit 8 clear.
- R4: When the estimate is above 3 and the two oldest entries are both skip symbols, the reader emits one skip and discards two entries. So with a faster writer, fewer skips leave than enter.
- R5: When the estimate is below 3 (but not 0) and the oldest entry is a skip, the reader emits that skip without consuming it. So with a slower writer, more skips leave than enter. R4 and R5 act at most once per skip run.
- R6: The write count runs from 0 to 11 and crosses the clock boundary as the code g = (c+2) xor ((c+2)>>1). Each increment, including 11 to 0, changes exactly one bit.
- R7: If the reader has started and finds the estimate at 0, it outputs the idle symbol and sets `unf_flag`.
- R8: An occupancy estimate above 6 sets `ovf_flag`.
- R9: Both flags stay set until the read-side reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Store `wr_sym` on this write-clock edge |
| wr_sym | input | 9 | Incoming symbol; bit 8 marks a control symbol |
| rd_clk | input | 1 | Local core clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_sym | output | 9 | Outgoing symbol, one per read-clock cycle |
| ovf_flag | output | 1 | Sticky: occupancy estimate exceeded the ring size |
| unf_flag | output | 1 | Sticky: reader found nothing to send after starting |

## Verification
The hardest condition to reach is a skip run at the head of the ring at the same moment the occupancy estimate is off target. That estimate is only visible through the sequence of symbols that come out. The bench gets there by skewing the write clock period 4 percent faster and then 4 percent slower than the read clock, while sending skip runs of three every eight symbols. It then compares the number of skips that enter with the number that leave. In parallel, a queue model checks that every data symbol arrives in order. Overflow is reached by writing at twice the read rate with no skips. Underflow is reached by stopping the writer right after the reader has started.

// File: rtl/eb_pkg.sv
package eb_pkg;

    localparam int SYM_W  = 9;
    localparam int CODE_W = 8;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [CODE_W-1:0] code_t;

    // Control symbols (bit 8 set)
    localparam sym_t SYM_SKIP = 9'h11C;
    localparam sym_t SYM_IDLE = 9'h17C;

    typedef enum logic [2:0] {
        ACT_WAIT,
        ACT_UNDER,
        ACT_PASS,
        ACT_DROP,
        ACT_REPEAT
    } rd_act_e;

    typedef struct packed {
        rd_act_e    act;
        sym_t       sym;
        logic [1:0] step;
    } rd_dec_t;

    // Count -> Gray, shifted by offs so a ring of 2*offs-free states is cyclic
    function automatic code_t count_to_gray(input code_t cnt, input code_t offs);
        code_t b;
        b = cnt + offs;
        return b ^ (b >> 1);
    endfunction

    function automatic code_t gray_to_count(input code_t g, input code_t offs);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b - offs;
    endfunction

endpackage

// File: rtl/eb_store.sv
module eb_store
    import eb_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  sym_t             wr_sym,
    input  logic [IDX_W-1:0] rd_idx0,
    input  logic [IDX_W-1:0] rd_idx1,
    output sym_t             rd_sym0,
    output sym_t             rd_sym1
);

    sym_t ring [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            ring[wr_idx] <= wr_sym;
        end
    end

    assign rd_sym0 = ring[rd_idx0];
    assign rd_sym1 = ring[rd_idx1];

endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side
    import eb_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                              wr_clk,
    input  logic                              wr_rst,
    input  logic                              wr_en,
    output logic [IDX_W-1:0]                  wr_idx,
    output logic [$clog2(2*DEPTH)-1:0]        wr_gray
);

    localparam int PTR_N = 2 * DEPTH;
    localparam int CNT_W = $clog2(PTR_N);
    localparam int OFFS  = ((1 << CNT_W) - PTR_N) / 2;
    localparam logic [CNT_W-1:0] GRAY0 =
        CNT_W'(count_to_gray(code_t'(0), code_t'(OFFS)));

    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] wcnt_nx;

    always_comb begin
        wcnt_nx = (int'(wcnt) == PTR_N - 1) ? '0 : wcnt + 1'b1;
        wr_idx  = (int'(wcnt) >= DEPTH) ? IDX_W'(int'(wcnt) - DEPTH) : IDX_W'(wcnt);
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wcnt    <= '0;
            wr_gray <= GRAY0;
        end else if (wr_en) begin
            wcnt    <= wcnt_nx;
            wr_gray <= CNT_W'(count_to_gray(code_t'(wcnt_nx), code_t'(OFFS)));
        end
    end

    // R6: single-bit change per write step, wrap included
    p_gray_onebit_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R6: the code always decodes to a legal count
    p_gray_legal_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        int'(gray_to_count(code_t'(wr_gray), code_t'(OFFS))) < PTR_N);

endmodule

// File: rtl/eb_sync.sv
module eb_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl
    import eb_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int TARGET = DEPTH / 2,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                         rd_clk,
    input  logic                         rd_rst,
    input  logic [$clog2(2*DEPTH)-1:0]   wr_gray_s,
    input  sym_t                         head_sym,
    input  sym_t                         next_sym,
    output logic [IDX_W-1:0]             rd_idx0,
    output logic [IDX_W-1:0]             rd_idx1,
    output sym_t                         rd_sym,
    output logic                         ovf,
    output logic                         unf
);

    localparam int PTR_N = 2 * DEPTH;
    localparam int CNT_W = $clog2(PTR_N);
    localparam int OCC_W = CNT_W + 1;
    localparam int OFFS  = ((1 << CNT_W) - PTR_N) / 2;

    logic [CNT_W-1:0] wcnt_s;
    logic [CNT_W-1:0] rcnt;
    logic [OCC_W-1:0] occ;
    logic             started;
    logic             adj_done;
    logic             head_skip;
    rd_dec_t          dec;

    function automatic logic [CNT_W-1:0] cnt_add(input logic [CNT_W-1:0] c, input int k);
        int s;
        s = int'(c) + k;
        if (s >= PTR_N) s = s - PTR_N;
        return CNT_W'(s);
    endfunction

    function automatic logic [IDX_W-1:0] to_idx(input logic [CNT_W-1:0] c);
        return (int'(c) >= DEPTH) ? IDX_W'(int'(c) - DEPTH) : IDX_W'(c);
    endfunction

    always_comb begin
        wcnt_s  = CNT_W'(gray_to_count(code_t'(wr_gray_s), code_t'(OFFS)));
        rd_idx0 = to_idx(rcnt);
        rd_idx1 = to_idx(cnt_add(rcnt, 1));
        if (wcnt_s >= rcnt) begin
            occ = OCC_W'(wcnt_s - rcnt);
        end else begin
            occ = OCC_W'(wcnt_s) + OCC_W'(PTR_N) - OCC_W'(rcnt);
        end
        head_skip = (head_sym == SYM_SKIP);
    end

    // One decision per read cycle
    always_comb begin
        dec.act  = ACT_PASS;
        dec.sym  = head_sym;
        dec.step = 2'd1;
        if (!started) begin
            dec.act  = ACT_WAIT;
            dec.sym  = SYM_IDLE;
            dec.step = 2'd0;
        end else if (occ == '0) begin
            dec.act  = ACT_UNDER;
            dec.sym  = SYM_IDLE;
            dec.step = 2'd0;
        end else if (head_skip && !adj_done && occ > OCC_W'(TARGET)
                     && next_sym == SYM_SKIP) begin
            dec.act  = ACT_DROP;
            dec.sym  = SYM_SKIP;
            dec.step = 2'd2;
        end else if (head_skip && !adj_done && occ < OCC_W'(TARGET)) begin
            dec.act  = ACT_REPEAT;
            dec.sym  = SYM_SKIP;
            dec.step = 2'd0;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rcnt     <= '0;
            started  <= 1'b0;
            adj_done <= 1'b0;
            rd_sym   <= SYM_IDLE;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            rd_sym <= dec.sym;
            rcnt   <= cnt_add(rcnt, int'(dec.step));
            if (!started && occ >= OCC_W'(TARGET)) begin
                started <= 1'b1;
            end
            if (dec.act == ACT_DROP || dec.act == ACT_REPEAT) begin
                adj_done <= 1'b1;
            end else if (dec.act == ACT_PASS && !head_skip) begin
                adj_done <= 1'b0;
            end
            if (dec.act == ACT_UNDER) begin
                unf <= 1'b1;
            end
            if (occ > OCC_W'(DEPTH)) begin
                ovf <= 1'b1;
            end
        end
    end

    // R2: idle symbols until the reader has started
    p_idle_before_start_r2: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !started |=> rd_sym == SYM_IDLE);

    // R3: the read count advances by 0, 1 or 2 only
    p_read_step_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rcnt == $past(rcnt)) || (rcnt == cnt_add($past(rcnt), 1))
        || (rcnt == cnt_add($past(rcnt), 2)));

    // R7: empty after start gives idle and the flag
    p_under_idle_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (started && occ == '0) |=> (rd_sym == SYM_IDLE && unf));

    // R8: an estimate beyond the ring size is flagged
    p_no_silent_overflow_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (occ > OCC_W'(DEPTH)) |=> ovf);

    // R9: flags are sticky
    p_ovf_sticky_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        ovf |=> ovf);
    p_unf_sticky_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        unf |=> unf);

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import eb_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int TARGET = DEPTH / 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic [SYM_W-1:0] wr_sym,
    input  logic             rd_clk,
    input  logic             rd_rst,
    output logic [SYM_W-1:0] rd_sym,
    output logic             ovf_flag,
    output logic             unf_flag
);

    localparam int PTR_N = 2 * DEPTH;
    localparam int CNT_W = $clog2(PTR_N);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OFFS  = ((1 << CNT_W) - PTR_N) / 2;
    localparam logic [CNT_W-1:0] GRAY0 =
        CNT_W'(count_to_gray(code_t'(0), code_t'(OFFS)));

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx0;
    logic [IDX_W-1:0] rd_idx1;
    logic [CNT_W-1:0] wr_gray;
    logic [CNT_W-1:0] wr_gray_s;
    sym_t             head_sym;
    sym_t             next_sym;

    eb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_sym  (wr_sym),
        .rd_idx0 (rd_idx0),
        .rd_idx1 (rd_idx1),
        .rd_sym0 (head_sym),
        .rd_sym1 (next_sym)
    );

    eb_wr_side #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_gray (wr_gray)
    );

    eb_sync #(.W(CNT_W), .RST_VAL(GRAY0)) u_sync (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wr_gray),
        .q   (wr_gray_s)
    );

    eb_rd_ctrl #(.DEPTH(DEPTH), .TARGET(TARGET), .IDX_W(IDX_W)) u_rd (
        .rd_clk    (rd_clk),
        .rd_rst    (rd_rst),
        .wr_gray_s (wr_gray_s),
        .head_sym  (head_sym),
        .next_sym  (next_sym),
        .rd_idx0   (rd_idx0),
        .rd_idx1   (rd_idx1),
        .rd_sym    (rd_sym),
        .ovf       (ovf_flag),
        .unf       (unf_flag)
    );

endmodule

// File: tb/test_rx_elastic_buf.sv
`timescale 1ns/10ps
module test_rx_elastic_buf;
    import eb_pkg::*;

    localparam real CLK_PERIOD = 10.0;
    localparam int  N_SCEN     = 3;
    localparam int  STREAM_LEN = 405;
    // write half period per scenario, expected skip trend (-1 fewer out, +1 more out, 0 any)
    localparam real SCEN_WHALF [N_SCEN] = '{5.0, 4.8, 5.2};
    localparam int  SCEN_TREND [N_SCEN] = '{0, -1, 1};

    logic rd_clk = 1'b0;
    logic wr_clk = 1'b0;
    logic wr_rst = 1'b1;
    logic rd_rst = 1'b1;
    logic wr_en  = 1'b0;
    logic [SYM_W-1:0] wr_sym = '0;
    logic [SYM_W-1:0] rd_sym;
    logic ovf_flag, unf_flag;

    real  wr_half = 5.0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    int   tx_skips, rx_skips;
    logic [7:0] byte_ctr = 8'h00;
    sym_t exp_q [$];

    rx_elastic_buf i_rx_elastic_buf (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_en    (wr_en),
        .wr_sym   (wr_sym),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_sym   (rd_sym),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    initial forever #(CLK_PERIOD / 2.0) rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 120000.0);
        check(1'b0, "watchdog", "run did not end", 0, 1);
        finish_run();
    end

    // Monitor: data symbols against the write-order model
    always @(negedge rd_clk) begin
        if (mon_on) begin
            if (rd_sym == SYM_SKIP) begin
                rx_skips++;
            end else if (rd_sym != SYM_IDLE) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "symbol with none expected", int'(rd_sym), 0);
                end else begin
                    sym_t e;
                    e = exp_q.pop_front();
                    check(rd_sym == e, "R3/R6", "data order", int'(rd_sym), int'(e));
                end
            end
        end
    end

    task automatic do_reset();
        wr_en  = 1'b0;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk) rd_rst = 1'b0;
        @(negedge wr_clk) wr_rst = 1'b0;
    endtask

    task automatic put(input sym_t s);
        @(negedge wr_clk);
        wr_en  = 1'b1;
        wr_sym = s;
        if (s == SYM_SKIP) tx_skips++;
        else exp_q.push_back(s);
    endtask

    task automatic wr_stop();
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    function automatic sym_t next_data();
        sym_t s;
        s = {1'b0, byte_ctr};
        byte_ctr = byte_ctr + 8'd1;
        return s;
    endfunction

    initial begin
        // R1: reset state, checked while reset is held and right after release
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_sym == SYM_IDLE, "R1", "idle during reset", int'(rd_sym), int'(SYM_IDLE));
        do_reset();
        @(negedge rd_clk);
        check(rd_sym == SYM_IDLE, "R1", "idle after reset", int'(rd_sym), int'(SYM_IDLE));
        check(ovf_flag == 1'b0, "R1", "ovf after reset", int'(ovf_flag), 0);
        check(unf_flag == 1'b0, "R1", "unf after reset", int'(unf_flag), 0);

        // Scenario table: equal, faster and slower writer
        for (int s = 0; s < N_SCEN; s++) begin
            wr_half = SCEN_WHALF[s];
            exp_q.delete();
            do_reset();
            tx_skips = 0;
            rx_skips = 0;
            mon_on   = 1'b1;
            for (int n = 0; n < STREAM_LEN; n++) begin
                if ((n % 8) < 5) put(next_data());
                else put(SYM_SKIP);
            end
            @(negedge rd_clk);
            check(ovf_flag == 1'b0, "R8", "no overflow in stream", int'(ovf_flag), 0);
            check(unf_flag == 1'b0, "R7", "no underflow in stream", int'(unf_flag), 0);
            wr_stop();
            repeat (20) @(negedge rd_clk);
            mon_on = 1'b0;
            check(exp_q.size() == 0, "R3", "all data delivered", exp_q.size(), 0);
            if (SCEN_TREND[s] < 0)
                check(rx_skips < tx_skips, "R4", "skips removed with fast writer", rx_skips, tx_skips);
            if (SCEN_TREND[s] > 0)
                check(rx_skips > tx_skips, "R5", "skips added with slow writer", rx_skips, tx_skips);
        end

        // R2 / R7: start threshold and underflow
        wr_half = 5.0;
        exp_q.delete();
        do_reset();
        begin
            sym_t d0, d1, d2;
            int   bad_idle;
            sym_t got [3];
            int   ngot;
            d0 = next_data(); d1 = next_data(); d2 = next_data();
            put(d0);
            put(d1);
            wr_stop();
            bad_idle = 0;
            repeat (20) begin
                @(negedge rd_clk);
                if (rd_sym != SYM_IDLE) bad_idle++;
            end
            check(bad_idle == 0, "R2", "idle below threshold", bad_idle, 0);
            check(unf_flag == 1'b0, "R2", "no underflow before start", int'(unf_flag), 0);
            put(d2);
            wr_stop();
            ngot = 0;
            repeat (20) begin
                @(negedge rd_clk);
                if (rd_sym != SYM_IDLE && ngot < 3) begin
                    got[ngot] = rd_sym;
                    ngot++;
                end
            end
            check(ngot == 3, "R2", "symbols after start", ngot, 3);
            check(got[0] == d0, "R2", "first symbol", int'(got[0]), int'(d0));
            check(got[1] == d1, "R3", "second symbol", int'(got[1]), int'(d1));
            check(got[2] == d2, "R3", "third symbol", int'(got[2]), int'(d2));
            check(unf_flag == 1'b1, "R7", "underflow after drain", int'(unf_flag), 1);
            check(rd_sym == SYM_IDLE, "R7", "idle while empty", int'(rd_sym), int'(SYM_IDLE));
        end

        // R8 / R9: overflow from a double-rate writer, sticky until reset
        exp_q.delete();
        wr_half = 2.5;
        do_reset();
        for (int n = 0; n < 80; n++) put(next_data());
        wr_stop();
        @(negedge rd_clk);
        check(ovf_flag == 1'b1, "R8", "overflow raised", int'(ovf_flag), 1);
        wr_half = 5.0;
        repeat (30) @(negedge rd_clk);
        check(ovf_flag == 1'b1, "R9", "overflow sticky", int'(ovf_flag), 1);
        check(unf_flag == 1'b1, "R9", "underflow sticky after drain", int'(unf_flag), 1);
        do_reset();
        @(negedge rd_clk);
        check(ovf_flag == 1'b0, "R9", "reset clears overflow", int'(ovf_flag), 0);
        check(unf_flag == 1'b0, "R9", "reset clears underflow", int'(unf_flag), 0);

        finish_run();
    end

endmodule